// File: doc/BRIEF.md
# Beam Sideband Demodulator

This block takes the sampled signal of a beam pickup and brings two narrow bands of it down to DC as I/Q pairs. The carrier path mixes the beam signal with a local oscillator at a chosen harmonic of the revolution frequency, which gives baseband amplitude and phase for a phase loop. The sideband path adds a small, finely programmed synchrotron offset to that oscillator. As a result, one synchrotron sideband, and not the carrier, falls at DC, where a coupled-bunch feedback can read it.

Both oscillators come from phase accumulators that advance once per sample. The revolution accumulator is multiplied by a harmonic number. The synchrotron accumulator is added on top, and each summed phase drives one quarter-wave sine/cosine generator. Each of the four mixer products passes through a power-of-two CIC decimator and then a short moving average. Software-side frequency words are taken up only on a load strobe, so an acceleration ramp changes the frequency without a jump in phase.

Top module: `beam_sb_demod`

## Requirements
- R1: While `rst` is high and in the first cycle after it, all four outputs read zero and `out_valid` stays low; all accumulators and loaded frequency words start at zero.
- R2: The accumulators advance by the loaded increments once per clock. The carrier phase is `harm * rev_acc` modulo 2^PW and the sideband phase is that value plus `syn_acc`. The sample presented at a clock edge is mixed with the phases the accumulators hold at that edge, so the first sample after reset meets phase zero.
- R3: `rev_inc`, `syn_inc` and `harm` have no effect until a clock edge with `cfg_load` high. The new words apply from the sample after that edge, and loading never clears an accumulator, so phase stays continuous.
- R4: A two's-complement negative `syn_inc` places the oscillator below the carrier harmonic and selects the lower sideband. With a zero synchrotron increment, the sideband and carrier phases keep a constant difference.
- R5: The oscillator takes the top QB+2 phase bits: the upper two bits are the quadrant and the rest is an index k, with N = 2^QB. The quarter amplitude is q(k) = floor(A·k·(2N−k)/N²) with A = 2^(AW−1)−1. Sine by quadrant 0..3 is q(k), q(N−k), −q(k), −q(N−k). Cosine is the sine of index+N, modulo 4N.
- R6: For each path, I = x·cos(phase) and Q = −x·sin(phase). `sb_i`/`sb_q` use the sideband phase and `car_i`/`car_q` use the carrier phase.
- R7: Each product goes through a CIC filter of order ORD that decimates by DEC. Its response is the ORD-fold convolution of a DEC-long all-ones window (triangular 1,2,…,DEC,…,2,1 for order 2). Result m covers samples up to index (m+1)·DEC−1, with earlier samples taken as zero. `out_valid` is a one-cycle pulse exactly every DEC clocks.
- R8: Each output equals floor(sum of the last MA CIC results / 2^(ORD·log2 DEC + log2 MA + AW − 1)), with results before the first one taken as zero. Outputs change only on the edge that raises `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processing clock, one sample per cycle |
| rst | input | 1 | Synchronous reset, active high |
| adc_in | input | DW | Signed beam pickup sample |
| cfg_load | input | 1 | Takes up the three frequency inputs at this edge |
| rev_inc | input | PW | Revolution phase increment per sample |
| syn_inc | input | PW | Synchrotron phase increment per sample, two's complement |
| harm | input | HW | Harmonic number multiplying the revolution phase |
| sb_i | output | OW | Sideband in-phase result |
| sb_q | output | OW | Sideband quadrature result |
| car_i | output | OW | Carrier in-phase result |
| car_q | output | OW | Carrier quadrature result |
| out_valid | output | 1 | One-cycle pulse when new results are present |

## Verification
A wrong accumulator or a wrongly latched frequency word makes a lasting phase error. It therefore shows in every following output pair, starting with the first output whose window holds the bad sample, which is at most about 2·DEC+MA·DEC samples later. A bad oscillator value or a misaligned decimation counter shows at the next strobe as I/Q values that differ from the arithmetic prediction. A drifting strobe shows at once as a gap other than DEC cycles. The bench rebuilds every output value from the samples it drove, using a closed-form window sum rather than integrators and combs. It sweeps tones, constants, extremes and pseudo-random data over many harmonic and offset settings.

// File: rtl/sbd_pkg.sv
package sbd_pkg;

  // Quarter-wave amplitude at index k of n = 2^qb steps, parabolic shape.
  function automatic longint quarter_amp(longint k, int qb, longint amp);
    longint two_n;
    two_n = longint'(2) << qb;
    return (amp * k * (two_n - k)) >>> (2 * qb);
  endfunction

  // Full-wave sine at index a in [0, 4*2^qb).
  function automatic longint wave_at(longint a, int qb, longint amp);
    longint n, k, quad;
    n    = longint'(1) << qb;
    quad = (a >>> qb) & longint'(3);
    k    = a & (n - 1);
    case (quad)
      longint'(0): return quarter_amp(k, qb, amp);
      longint'(1): return quarter_amp(n - k, qb, amp);
      longint'(2): return -quarter_amp(k, qb, amp);
      default:     return -quarter_amp(n - k, qb, amp);
    endcase
  endfunction

endpackage

// File: rtl/sbd_nco.sv
module sbd_nco #(
  parameter int PW = 32,
  parameter int HW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_load,
  input  logic [PW-1:0] rev_inc_in,
  input  logic [PW-1:0] syn_inc_in,
  input  logic [HW-1:0] harm_in,
  output logic [PW-1:0] ph_car,
  output logic [PW-1:0] ph_sb,
  output logic          ph_v
);
  logic [PW-1:0] rev_inc_q, syn_inc_q, rev_acc, syn_acc;
  logic [HW-1:0] harm_q;
  logic [PW-1:0] car_now;
  logic [1:0]    armed;

  assign car_now = {{(PW-HW){1'b0}}, harm_q} * rev_acc;

  always_ff @(posedge clk) begin
    if (rst) begin
      rev_inc_q <= '0;
      syn_inc_q <= '0;
      harm_q    <= '0;
      rev_acc   <= '0;
      syn_acc   <= '0;
      ph_car    <= '0;
      ph_sb     <= '0;
      ph_v      <= 1'b0;
      armed     <= '0;
    end else begin
      if (cfg_load) begin
        rev_inc_q <= rev_inc_in;
        syn_inc_q <= syn_inc_in;
        harm_q    <= harm_in;
      end
      rev_acc <= rev_acc + rev_inc_q;
      syn_acc <= syn_acc + syn_inc_q;
      ph_car  <= car_now;
      ph_sb   <= car_now + syn_acc;
      ph_v    <= 1'b1;
      if (armed != 2'd2) armed <= armed + 2'd1;
    end
  end

  // Frequency words move only on a load strobe.
  assert_cfg_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !cfg_load |=> ($stable(rev_inc_q) && $stable(syn_inc_q) && $stable(harm_q)));

  // Without a synchrotron increment the two phases keep a fixed distance.
  assert_sb_offset_R4: assert property (@(posedge clk) disable iff (rst)
    (armed == 2'd2 && $past(syn_inc_q, 2) == '0) |->
      ((ph_sb - ph_car) == $past(ph_sb - ph_car)));
endmodule

// File: rtl/sbd_mixer.sv
module sbd_mixer #(
  parameter int DW = 16,
  parameter int AW = 16,
  parameter int PW = 32,
  parameter int QB = 8,
  localparam int PRW = DW + AW
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  ph_v,
  input  logic [PW-1:0]         ph_sb,
  input  logic [PW-1:0]         ph_car,
  input  logic signed [DW-1:0]  x_in,
  output logic signed [PRW-1:0] prod [4],
  output logic                  prod_v
);
  import sbd_pkg::*;
  localparam int     NQ  = 1 << QB;
  localparam longint AMP = (longint'(1) << (AW - 1)) - 1;

  logic [QB+1:0]         idx    [2];
  logic signed [AW-1:0]  lo_cos [2];
  logic signed [AW-1:0]  lo_sin [2];
  logic [AW:0]           lo_mag [2];
  logic signed [DW-1:0]  x2;
  logic                  va;

  assign idx[0] = ph_sb[PW-1 -: QB+2];
  assign idx[1] = ph_car[PW-1 -: QB+2];

  always_ff @(posedge clk) begin
    if (rst) begin
      va <= 1'b0;
      x2 <= '0;
      for (int g = 0; g < 2; g++) begin
        lo_cos[g] <= '0;
        lo_sin[g] <= '0;
      end
    end else begin
      va <= ph_v;
      x2 <= x_in;
      for (int g = 0; g < 2; g++) begin
        lo_sin[g] <= AW'(wave_at(longint'(idx[g]), QB, AMP));
        lo_cos[g] <= AW'(wave_at((longint'(idx[g]) + NQ) & longint'(4 * NQ - 1), QB, AMP));
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prod_v <= 1'b0;
      for (int c = 0; c < 4; c++) prod[c] <= '0;
    end else begin
      prod_v <= va;
      for (int g = 0; g < 2; g++) begin
        prod[2*g]   <= PRW'(x2 * lo_cos[g]);
        prod[2*g+1] <= -PRW'(x2 * lo_sin[g]);
      end
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_mag
    assign lo_mag[g] = (AW+1)'(lo_cos[g] < 0 ? -lo_cos[g] : lo_cos[g])
                     + (AW+1)'(lo_sin[g] < 0 ? -lo_sin[g] : lo_sin[g]);
    // Sine and cosine of one phase never vanish together.
    assert_lo_amplitude_R5: assert property (@(posedge clk) disable iff (rst)
      va |-> (lo_mag[g] >= (AW+1)'(AMP - 1)));
  end
endmodule

// File: rtl/sbd_dec_ctl.sv
module sbd_dec_ctl #(
  parameter int DEC = 64,
  localparam int RB = $clog2(DEC)
) (
  input  logic clk,
  input  logic rst,
  input  logic vin,
  output logic dec,
  output logic comb_v,
  output logic out_v
);
  logic [RB-1:0] cnt;
  logic [15:0]   gap;
  logic          seen;

  assign dec = vin && (cnt == RB'(DEC - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      comb_v <= 1'b0;
      out_v  <= 1'b0;
      gap    <= '0;
      seen   <= 1'b0;
    end else begin
      if (vin) cnt <= cnt + 1'b1;
      comb_v <= dec;
      out_v  <= comb_v;
      if (out_v) gap <= '0;
      else if (gap != '1) gap <= gap + 1'b1;
      seen <= seen | out_v;
    end
  end

  // Strobes are spaced exactly by the decimation factor.
  assert_valid_period_R7: assert property (@(posedge clk) disable iff (rst)
    (out_v && seen) |-> (gap == 16'(DEC - 1)));
endmodule

// File: rtl/sbd_chan.sv
module sbd_chan #(
  parameter int IW  = 32,
  parameter int DEC = 64,
  parameter int ORD = 2,
  parameter int MA  = 4,
  parameter int OW  = 18,
  parameter int SH  = 29,
  localparam int RB = $clog2(DEC),
  localparam int MB = $clog2(MA),
  localparam int CW = IW + ORD * RB,
  localparam int SW = CW + MB
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 vin,
  input  logic                 dec,
  input  logic                 comb_v,
  input  logic signed [IW-1:0] din,
  output logic signed [OW-1:0] y
);
  logic signed [CW-1:0] integ [ORD];
  logic signed [CW-1:0] sig   [ORD+1];
  logic signed [CW-1:0] dly   [ORD];
  logic signed [CW-1:0] cc    [ORD+1];
  logic signed [CW-1:0] comb_q;
  logic signed [CW-1:0] hist  [MA];
  logic signed [SW-1:0] ma_sum, ma_next;

  always_comb begin
    sig[0] = CW'(din);
    for (int k = 0; k < ORD; k++) sig[k+1] = integ[k] + sig[k];
    cc[0] = sig[ORD];
    for (int k = 0; k < ORD; k++) cc[k+1] = cc[k] - dly[k];
  end

  assign ma_next = ma_sum + SW'(comb_q) - SW'(hist[MA-1]);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < ORD; k++) begin
        integ[k] <= '0;
        dly[k]   <= '0;
      end
      comb_q <= '0;
    end else begin
      if (vin) for (int k = 0; k < ORD; k++) integ[k] <= sig[k+1];
      if (dec) begin
        for (int k = 0; k < ORD; k++) dly[k] <= cc[k];
        comb_q <= cc[ORD];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < MA; k++) hist[k] <= '0;
      ma_sum <= '0;
      y      <= '0;
    end else if (comb_v) begin
      hist[0] <= comb_q;
      for (int k = 1; k < MA; k++) hist[k] <= hist[k-1];
      ma_sum <= ma_next;
      y      <= OW'(ma_next >>> SH);
    end
  end

  // Results hold between strobes.
  assert_hold_between_R8: assert property (@(posedge clk) disable iff (rst)
    !comb_v |=> $stable(y));
endmodule

// File: rtl/beam_sb_demod.sv
module beam_sb_demod #(
  parameter int DW  = 16,
  parameter int AW  = 16,
  parameter int PW  = 32,
  parameter int HW  = 8,
  parameter int QB  = 8,
  parameter int DEC = 64,
  parameter int ORD = 2,
  parameter int MA  = 4,
  parameter int OW  = DW + 2,
  localparam int PRW = DW + AW,
  localparam int SH  = ORD * $clog2(DEC) + $clog2(MA) + AW - 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic signed [DW-1:0] adc_in,
  input  logic                 cfg_load,
  input  logic [PW-1:0]        rev_inc,
  input  logic [PW-1:0]        syn_inc,
  input  logic [HW-1:0]        harm,
  output logic signed [OW-1:0] sb_i,
  output logic signed [OW-1:0] sb_q,
  output logic signed [OW-1:0] car_i,
  output logic signed [OW-1:0] car_q,
  output logic                 out_valid
);
  logic [PW-1:0]         ph_car, ph_sb;
  logic                  ph_v, prod_v, dec, comb_v;
  logic signed [DW-1:0]  x1;
  logic signed [PRW-1:0] prod [4];
  logic signed [OW-1:0]  res  [4];

  always_ff @(posedge clk) begin
    if (rst) x1 <= '0;
    else     x1 <= adc_in;
  end

  sbd_nco #(.PW(PW), .HW(HW)) u_nco (
    .clk(clk), .rst(rst), .cfg_load(cfg_load),
    .rev_inc_in(rev_inc), .syn_inc_in(syn_inc), .harm_in(harm),
    .ph_car(ph_car), .ph_sb(ph_sb), .ph_v(ph_v)
  );

  sbd_mixer #(.DW(DW), .AW(AW), .PW(PW), .QB(QB)) u_mix (
    .clk(clk), .rst(rst), .ph_v(ph_v), .ph_sb(ph_sb), .ph_car(ph_car),
    .x_in(x1), .prod(prod), .prod_v(prod_v)
  );

  sbd_dec_ctl #(.DEC(DEC)) u_ctl (
    .clk(clk), .rst(rst), .vin(prod_v),
    .dec(dec), .comb_v(comb_v), .out_v(out_valid)
  );

  for (genvar c = 0; c < 4; c++) begin : g_chan
    sbd_chan #(.IW(PRW), .DEC(DEC), .ORD(ORD), .MA(MA), .OW(OW), .SH(SH)) u_ch (
      .clk(clk), .rst(rst), .vin(prod_v), .dec(dec), .comb_v(comb_v),
      .din(prod[c]), .y(res[c])
    );
  end

  assign sb_i  = res[0];
  assign sb_q  = res[1];
  assign car_i = res[2];
  assign car_q = res[3];
endmodule

// File: tb/sim_beam_sb_demod.sv
module sim_beam_sb_demod;
  localparam int DW = 16, AW = 16, PW = 32, HW = 8, QB = 4;
  localparam int DEC = 4, ORD = 2, MA = 2, OW = 18;
  localparam int SH = 2 * 2 + 1 + AW - 1;
  localparam int NQ = 1 << QB;
  localparam longint AMPB = 32767;
  localparam int MAXS = 8192, MAXO = 2048;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic                 rst = 1'b1;
  logic signed [DW-1:0] adc_in = '0;
  logic                 cfg_load = 1'b0;
  logic [PW-1:0]        rev_inc = '0, syn_inc = '0;
  logic [HW-1:0]        harm = '0;
  logic signed [OW-1:0] sb_i, sb_q, car_i, car_q;
  logic                 out_valid;

  beam_sb_demod #(.DW(DW), .AW(AW), .PW(PW), .HW(HW), .QB(QB),
                  .DEC(DEC), .ORD(ORD), .MA(MA), .OW(OW)) u0 (
    .clk(clk), .rst(rst), .adc_in(adc_in), .cfg_load(cfg_load),
    .rev_inc(rev_inc), .syn_inc(syn_inc), .harm(harm),
    .sb_i(sb_i), .sb_q(sb_q), .car_i(car_i), .car_q(car_q), .out_valid(out_valid)
  );

  int checks = 0, fails = 0;
  string tag = "R1";

  // Bench model state
  longint p_ch [4][MAXS];
  longint c_ch [4][MAXO];
  int ns = 0, no = 0;
  longint cyc = 0, last_v = 0;
  logic [31:0] m_racc = '0, m_sacc = '0, m_rinc = '0, m_sinc = '0;
  logic [7:0]  m_harm = '0;

  // Stimulus state
  int mode = 0;
  logic signed [15:0] cval = '0;
  logic [31:0] tone_acc = '0, tone_inc = '0;
  logic [15:0] lfsr = 16'hACE1;
  logic        alt = 1'b0;

  function automatic longint bq(longint m);
    return (AMPB * m * (2 * NQ - m)) / (NQ * NQ);
  endfunction

  function automatic longint bsin(int a);
    int u, m;
    u = a % (2 * NQ);
    m = (u <= NQ) ? u : 2 * NQ - u;
    return (a >= 2 * NQ) ? -bq(longint'(m)) : bq(longint'(m));
  endfunction

  function automatic longint bcos(int a);
    return bsin((a + NQ) % (4 * NQ));
  endfunction

  task automatic check(string t, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", t, what, act, exp);
    end
  endtask

  // Reference model: capture each sample with the phase held at that edge.
  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      ns = 0; m_racc = '0; m_sacc = '0; m_rinc = '0; m_sinc = '0; m_harm = '0;
    end else begin
      logic [31:0] car, sbp;
      longint x;
      int ac, as;
      car = 32'(longint'(m_harm) * longint'(m_racc));
      sbp = car + m_sacc;
      ac  = int'(car[31:26]);
      as  = int'(sbp[31:26]);
      x   = longint'(adc_in);
      if (ns < MAXS) begin
        p_ch[0][ns] = x * bcos(as);
        p_ch[1][ns] = -(x * bsin(as));
        p_ch[2][ns] = x * bcos(ac);
        p_ch[3][ns] = -(x * bsin(ac));
      end
      ns++;
      m_racc = m_racc + m_rinc;
      m_sacc = m_sacc + m_sinc;
      if (cfg_load) begin
        m_rinc = rev_inc; m_sinc = syn_inc; m_harm = harm;
      end
    end
  end

  // Output checker, away from the active edge.
  always @(negedge clk) begin
    if (rst) begin
      check("R1", "reset outputs", longint'(sb_i) | longint'(sb_q) | longint'(car_i)
            | longint'(car_q) | longint'(out_valid), 0);
    end else if (out_valid && no < MAXO) begin
      longint exp, got;
      if (no > 0) check("R7", "strobe spacing", cyc - last_v, DEC);
      last_v = cyc;
      for (int c = 0; c < 4; c++) begin
        longint acc;
        acc = 0;
        for (int i = 0; i <= 2 * DEC - 2; i++) begin
          int n, w;
          n = (no + 1) * DEC - 1 - i;
          w = (i < DEC) ? i + 1 : 2 * DEC - 1 - i;
          if (n >= 0) acc += longint'(w) * p_ch[c][n];
        end
        c_ch[c][no] = acc;
        exp = 0;
        for (int j = 0; j < MA; j++) if (no - j >= 0) exp += c_ch[c][no - j];
        exp = exp >>> SH;
        case (c)
          0: got = longint'(sb_i);
          1: got = longint'(sb_q);
          2: got = longint'(car_i);
          default: got = longint'(car_q);
        endcase
        check(tag, $sformatf("R6 R7 R8 channel %0d output %0d", c, no), got, exp);
      end
      no++;
    end
  end

  task automatic drive_adc();
    case (mode)
      0: adc_in = cval;
      1: begin
        adc_in = 16'(bcos(int'(tone_acc[31:26])));
        tone_acc = tone_acc + tone_inc;
      end
      2: begin
        adc_in = alt ? 16'sh7FFF : 16'sh8000;
        alt = ~alt;
      end
      default: begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        adc_in = lfsr;
      end
    endcase
  endtask

  task automatic step(int n);
    repeat (n) begin
      @(negedge clk);
      cfg_load = 1'b0;
      drive_adc();
    end
  endtask

  task automatic load(logic [31:0] r, logic [31:0] s, logic [7:0] h);
    @(negedge clk);
    rev_inc = r; syn_inc = s; harm = h; cfg_load = 1'b1;
    drive_adc();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run did not finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: first cycle after reset, nothing yet
    check("R1", "idle strobe after reset", longint'(out_valid), 0);

    // R2 R6: phase zero, constant input
    tag = "R2"; mode = 0; cval = 16'sd1000;
    step(40);
    cval = -16'sd21000;
    step(24);

    // R4: upper sideband tone lands at DC
    tag = "R4"; load(32'h0400_0000, 32'h0008_0000, 8'd3);
    mode = 1; tone_inc = 32'h0C08_0000;
    step(200);

    // R3: words presented without a load strobe are ignored
    tag = "R3"; rev_inc = 32'h1234_5678; syn_inc = 32'h0ABC_0000; harm = 8'd77;
    step(60);

    // R4: lower sideband with negative offset, random data
    tag = "R4"; load(32'h0400_0000, 32'hFFF8_0000, 8'd3);
    mode = 3;
    step(150);

    // R6: extreme samples
    tag = "R6"; mode = 2;
    step(60);

    // R5: sweep harmonic numbers and offsets
    tag = "R5";
    for (int h = 0; h < 10; h++) begin
      logic [31:0] r, s;
      r = 32'h0200_0000 + 32'(h) * 32'h0011_0000;
      s = 32'(h) * 32'h0000_1000;
      load(r, s, 8'(h));
      mode = 1; tone_inc = 32'(longint'(h) * longint'(r)) + s;
      step(48);
    end

    // R2: largest harmonic, near half-turn increment
    tag = "R2"; load(32'h7FFF_FFFF, 32'h0001_0000, 8'd255);
    mode = 3;
    step(60);

    step(40);
    if (no < 20) check("R7", "strobe count", longint'(no), 20);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule